// File: doc/BRIEF.md
# Staged-Commit Multi-Channel DAC Bus Controller

This block is the digital control core of a multi-channel 8-bit DAC that a host programs over a two-wire serial bus. The block samples the clock line and the data line with the system clock and removes short glitches from them. It detects START, repeated START and STOP conditions, compares the address byte against a fixed prefix plus strap inputs, and pulls the data line low in the acknowledge slot of every byte it accepts. Command bytes select a channel and carry a reset flag and a power-down flag. Output bytes land in a per-channel input latch.

Nothing reaches the analog side until the host ends the frame. On a STOP of a frame that addressed this device and carried at least one complete command byte, the block copies every input latch into its output latch in the same cycle and takes up the last pending power-down value. The block has exact rules for frames that are cut short by an early STOP or by a repeated START to another device. The state machine has these states:
- IDLE (bus free)
- ADDR (shifting the address byte) and ADDR_ACK
- CMD (shifting a command byte) and CMD_ACK
- DATA (shifting an output byte) and DATA_ACK
- SKIP (frame not for this device)

Any START moves the machine to ADDR, and any STOP moves it to IDLE. Eight bits followed by a falling clock move it from a shift state to the matching ack state. A matched address goes to ADDR_ACK, and a mismatch goes to SKIP. The falling clock that ends each ack slot moves ADDR_ACK to CMD, CMD_ACK to DATA, and DATA_ACK back to CMD.

Top module: `dac_bus_ctrl`

## Requirements
- R1: After reset, every channel word is 0x00, the power-down output is 0 and the data-line pull-down is released.
- R2: The device answers only address bytes whose upper seven bits are 0101, then 0, then strap_i[1], then strap_i[0] (eight-channel build), and whose last bit (write flag) is 0. Any other address gets no acknowledge, and the rest of that frame, STOP included, is ignored.
- R3: The device drives the data line low during the ninth clock pulse of each byte it accepts: the address byte, each command byte and each output byte.
- R4: Command byte bits are [4] reset flag, [3] power-down flag and [2:0] channel number; bits [7:5] are don't-care. The output byte that follows a command is stored for the selected channel.
- R5: Channel words change only on a STOP of a matched frame that holds at least one complete command byte, and all channels update together.
- R6: A command byte that ends the frame applies only its reset and power-down flags. The power-down output takes the flag of the last complete command byte of the frame, at STOP.
- R7: A command with the reset flag set clears all staged values and causes its output byte to be discarded. Later pairs in the same frame write over the cleared values.
- R8: A STOP in the middle of a command byte discards that partial byte and keeps all earlier complete pairs.
- R9: A STOP in the middle of an output byte keeps the earlier pairs and applies the reset and power-down flags of the command before it, but discards the partial data.
- R10: A repeated START to a different address leaves staged values uncommitted. A later matched frame with at least one command byte and a STOP commits them.
- R11: START is a falling data line while the clock is high, and STOP is a rising data line while the clock is high. A clock pulse shorter than FILT system clocks is not counted as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, raw |
| sda_i | input | 1 | Bus data line as seen on the wire, raw |
| strap_i | input | 3 | Address strap inputs (eight-channel build uses bits 1:0) |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| dac_word | output | NCH*DW | Committed channel words, channel n at bits n*DW +: DW |
| pwr_down | output | 1 | Committed power-down state |

## Verification
The bench targets the frame-shortening cases. These are an early STOP inside a command byte, where a design that used the partial bits would pick up a stray reset or power-down, and an early STOP inside an output byte, where a design would either drop the pending flags or store half a byte. It also sends a repeated START to a foreign address and checks that no commit happens until a later lone-command frame. A design that committed on any STOP would update too early, and one that cleared staging on START would lose the earlier data. The reset-flag pair must swallow its output byte. A short clock glitch in the middle of a byte must not shift an extra bit, or the stored value comes out rotated.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } dbc_state_e;

    localparam logic [3:0] DBC_ADDR_PREFIX = 4'b0101;
    localparam int         DBC_BYTE_BITS   = 8;
    localparam int         DBC_RST_BIT     = 4;
    localparam int         DBC_PD_BIT      = 3;

endpackage

// File: rtl/dbc_deglitch.sv
module dbc_deglitch #(
    parameter int   FILT    = 4,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= {2{RST_VAL}};
            clean_o <= RST_VAL;
            cnt_q   <= '0;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] != clean_o) begin
                if (cnt_q == CW'(FILT - 1)) begin
                    clean_o <= sync_q[1];
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/dbc_bus_cond.sv
module dbc_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        start_o = scl_i & scl_q & sda_q & ~sda_i;
        stop_o  = scl_i & scl_q & ~sda_q & sda_i;
        rise_o  = scl_i & ~scl_q;
        fall_o  = ~scl_i & scl_q;
    end
endmodule

// File: rtl/dbc_latch_bank.sv
module dbc_latch_bank #(
    parameter int NCH = 8,
    parameter int DW  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_all,
    input  logic                  wr_en,
    input  logic [$clog2(NCH)-1:0] wr_idx,
    input  logic [DW-1:0]         wr_data,
    input  logic                  commit,
    output logic [NCH*DW-1:0]     out_flat
);
    localparam int IW = $clog2(NCH);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [DW-1:0] stage_q;
        logic [DW-1:0] live_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
                live_q  <= '0;
            end else begin
                if (clr_all)
                    stage_q <= '0;
                else if (wr_en && wr_idx == IW'(g))
                    stage_q <= wr_data;
                if (commit)
                    live_q <= stage_q;
            end
        end

        assign out_flat[g*DW +: DW] = live_q;
    end
endmodule

// File: rtl/dac_bus_ctrl.sv
module dac_bus_ctrl
    import dbc_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int DW   = 8,
    parameter int FILT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    output logic              sda_oe,
    output logic [NCH*DW-1:0] dac_word,
    output logic              pwr_down
);
    localparam int IW = $clog2(NCH);

    logic scl_c, sda_c;
    logic start_p, stop_p, scl_rise, scl_fall;

    dbc_deglitch #(.FILT(FILT), .RST_VAL(1'b1)) u_scl_flt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_c));
    dbc_deglitch #(.FILT(FILT), .RST_VAL(1'b1)) u_sda_flt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_c));

    dbc_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_c), .sda_i(sda_c),
        .start_o(start_p), .stop_o(stop_p), .rise_o(scl_rise), .fall_o(scl_fall));

    dbc_state_e state_q, state_n;

    logic [3:0]    bitcnt_q;
    logic [7:0]    shift_q;
    logic          matched;
    logic          cmd_seen_q;
    logic          pend_pd_q;
    logic          skip_data_q;
    logic [IW-1:0] chan_q;

    logic [6:0] own_addr;
    logic       addr_hit;
    logic       byte_end;
    logic       shifting;
    logic       in_ack;
    logic       lb_clr, lb_wr, commit;

    if (NCH == 8) begin : g_addr_oct
        assign own_addr = {DBC_ADDR_PREFIX, 1'b0, strap_i[1:0]};
    end else begin : g_addr_quad
        assign own_addr = {DBC_ADDR_PREFIX, strap_i};
    end

    always_comb begin
        shifting = (state_q == ST_ADDR) || (state_q == ST_CMD) || (state_q == ST_DATA);
        in_ack   = (state_q == ST_ADDR_ACK) || (state_q == ST_CMD_ACK) ||
                   (state_q == ST_DATA_ACK);
        byte_end = shifting && scl_fall && (bitcnt_q == 4'(DBC_BYTE_BITS));
        addr_hit = (shift_q[7:1] == own_addr) && !shift_q[0];
        lb_clr   = (state_q == ST_CMD) && byte_end && shift_q[DBC_RST_BIT];
        lb_wr    = (state_q == ST_DATA) && byte_end && !skip_data_q;
        commit   = stop_p && matched && cmd_seen_q;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        if (start_p) begin
            state_n = ST_ADDR;
        end else if (stop_p) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:     if (byte_end) state_n = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) state_n = ST_CMD;
                ST_CMD:      if (byte_end) state_n = ST_CMD_ACK;
                ST_CMD_ACK:  if (scl_fall) state_n = ST_DATA;
                ST_DATA:     if (byte_end) state_n = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_n = ST_CMD;
                ST_SKIP:     state_n = ST_SKIP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // outputs and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q    <= '0;
            shift_q     <= '0;
            matched     <= 1'b0;
            cmd_seen_q  <= 1'b0;
            pend_pd_q   <= 1'b0;
            skip_data_q <= 1'b0;
            chan_q      <= '0;
            sda_oe      <= 1'b0;
            pwr_down    <= 1'b0;
        end else if (start_p) begin
            bitcnt_q    <= '0;
            matched     <= 1'b0;
            cmd_seen_q  <= 1'b0;
            skip_data_q <= 1'b0;
            sda_oe      <= 1'b0;
        end else if (stop_p) begin
            if (commit) pwr_down <= pend_pd_q;
            bitcnt_q   <= '0;
            matched    <= 1'b0;
            cmd_seen_q <= 1'b0;
            sda_oe     <= 1'b0;
        end else begin
            if (shifting && scl_rise) begin
                shift_q  <= {shift_q[6:0], sda_c};
                bitcnt_q <= bitcnt_q + 1'b1;
            end
            if (byte_end) begin
                bitcnt_q <= '0;
                unique case (state_q)
                    ST_ADDR: begin
                        if (addr_hit) begin
                            matched <= 1'b1;
                            sda_oe  <= 1'b1;
                        end
                    end
                    ST_CMD: begin
                        pend_pd_q   <= shift_q[DBC_PD_BIT];
                        skip_data_q <= shift_q[DBC_RST_BIT];
                        chan_q      <= shift_q[IW-1:0];
                        cmd_seen_q  <= 1'b1;
                        sda_oe      <= 1'b1;
                    end
                    ST_DATA: sda_oe <= 1'b1;
                    default: sda_oe <= 1'b0;
                endcase
            end else if (in_ack && scl_fall) begin
                sda_oe <= 1'b0;
            end
        end
    end

    dbc_latch_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .clr_all(lb_clr), .wr_en(lb_wr), .wr_idx(chan_q), .wr_data(shift_q),
        .commit(commit), .out_flat(dac_word));

endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
    parameter int NCH = 8,
    parameter int DW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              pwr_down,
    input logic [NCH*DW-1:0] dac_word,
    input logic              start_p,
    input logic              stop_p,
    input logic              scl_rise,
    input logic              scl_fall,
    input logic              scl_c,
    input logic              matched
);
    AST_WORDS_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_word) |-> $past(stop_p)); // R5
    AST_PD_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_down) |-> $past(stop_p)); // R6
    AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> matched); // R2
    AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall)); // R3
    AST_ACK_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!scl_c || $past(start_p) || $past(stop_p))); // R3
    AST_ONE_BUS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_p, stop_p, scl_rise, scl_fall})); // R11
endmodule

bind dac_bus_ctrl dbc_checker #(.NCH(NCH), .DW(DW)) u_dbc_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .pwr_down(pwr_down),
    .dac_word(dac_word), .start_p(start_p), .stop_p(stop_p),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .scl_c(scl_c), .matched(matched));

// File: tb/dac_bus_ctrl_bench.sv
module dac_bus_ctrl_bench;
    localparam int Q = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'b110;
    logic        sda_oe;
    logic [63:0] dac_word;
    logic        pwr_down;
    logic        sda_wire;

    assign sda_wire = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    dac_bus_ctrl u_dac_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_wire),
        .strap_i(strap), .sda_oe(sda_oe), .dac_word(dac_word), .pwr_down(pwr_down));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0]  exp_w [8];
    logic        exp_pd;
    logic [63:0] q_words [$];
    logic        q_pd [$];
    string       q_tag [$];
    event        chk_ev;

    function automatic logic [63:0] pack_exp();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = exp_w[i];
        return v;
    endfunction

    task automatic wq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_state(string tag);
        q_words.push_back(pack_exp());
        q_pd.push_back(exp_pd);
        q_tag.push_back(tag);
        -> chk_ev;
    endtask

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q_tag.size() > 0) begin
                logic [63:0] ew;
                logic        ep;
                string       t;
                ew = q_words.pop_front();
                ep = q_pd.pop_front();
                t  = q_tag.pop_front();
                n_chk++;
                if (dac_word !== ew || pwr_down !== ep) begin
                    n_bad++;
                    $display("FAIL %s: words=%h pd=%b expected words=%h pd=%b",
                             t, dac_word, pwr_down, ew, ep);
                end
            end
        end
    end

    task automatic send_bits(input logic [7:0] b, input int n, input int glitch_at);
        for (int i = 0; i < n; i++) begin
            if (i == glitch_at) begin
                wq(4); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(Q - 6);
            end else begin
                wq(Q);
            end
            sda_m = b[7 - i];
            wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag,
                             input int glitch_at = -1);
        send_bits(b, 8, glitch_at);
        wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        n_chk++;
        if (sda_oe !== exp_ack) begin
            n_bad++;
            $display("FAIL %s ack: got %b expected %b (byte %h)", tag, sda_oe, exp_ack, b);
        end
        wq(Q); scl_m = 1'b0;
    endtask

    task automatic start_cond();
        wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0;
    endtask

    task automatic stop_cond();
        wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(4 * Q);
    endtask

    localparam logic [7:0] ADDR_OK = 8'h54;

    initial begin
        for (int i = 0; i < 8; i++) exp_w[i] = 8'h00;
        exp_pd = 1'b0;
        wq(5);
        rst_n = 1'b1;
        wq(3);
        // R1 reset state
        n_chk++;
        if (sda_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: sda_oe=%b expected 0", sda_oe);
        end
        expect_state("R1 reset");

        // R4 R3 basic pairs, R5 nothing moves before STOP
        start_cond();
        send_byte(ADDR_OK, 1'b1, "R3 addr");
        send_byte(8'h00, 1'b1, "R3 cmd");
        send_byte(8'hFF, 1'b1, "R3 data");
        send_byte(8'h01, 1'b1, "R4 cmd");
        send_byte(8'h81, 1'b1, "R4 data");
        wq(Q);
        expect_state("R5 held before stop");
        send_byte(8'h07, 1'b1, "R4 cmd");
        send_byte(8'h3C, 1'b1, "R4 data");
        stop_cond();
        exp_w[0] = 8'hFF; exp_w[1] = 8'h81; exp_w[7] = 8'h3C;
        expect_state("R4 R5 commit");

        // R2 address mismatch and read flag
        start_cond();
        send_byte(8'h56, 1'b0, "R2 wrong addr");
        send_byte(8'h00, 1'b0, "R2 cmd ignored");
        send_byte(8'h12, 1'b0, "R2 data ignored");
        stop_cond();
        expect_state("R2 mismatch ignored");
        start_cond();
        send_byte(8'h55, 1'b0, "R2 read flag");
        stop_cond();
        expect_state("R2 read ignored");

        // R6 lone power-down command, then last-command-wins
        start_cond();
        send_byte(ADDR_OK, 1'b1, "R3 addr");
        send_byte(8'h08, 1'b1, "R6 cmd pd");
        stop_cond();
        exp_pd = 1'b1;
        expect_state("R6 lone pd");
        start_cond();
        send_byte(ADDR_OK, 1'b1, "R3 addr");
        send_byte(8'h0B, 1'b1, "R6 cmd pd ch3");
        send_byte(8'h11, 1'b1, "R6 data");
        send_byte(8'h00, 1'b1, "R6 last cmd");
        stop_cond();
        exp_pd = 1'b0; exp_w[3] = 8'h11;
        expect_state("R6 last cmd wins");

        // R7 reset flag clears staging and swallows its output byte
        start_cond();
        send_byte(ADDR_OK, 1'b1, "R3 addr");
        send_byte(8'h10, 1'b1, "R7 cmd rst");
        send_byte(8'h77, 1'b1, "R7 dummy");
        send_byte(8'h02, 1'b1, "R7 cmd ch2");
        send_byte(8'h5A, 1'b1, "R7 data");
        wq(Q);
        expect_state("R5 outputs held mid frame");
        stop_cond();
        for (int i = 0; i < 8; i++) exp_w[i] = 8'h00;
        exp_w[2] = 8'h5A;
        expect_state("R7 reset commit");

        // R8 STOP inside a command byte
        start_cond();
        send_byte(ADDR_OK, 1'b1, "R3 addr");
        send_byte(8'h04, 1'b1, "R8 cmd ch4");
        send_byte(8'h99, 1'b1, "R8 data");
        send_bits(8'b0001_1000, 5, -1);
        stop_cond();
        exp_w[4] = 8'h99;
        expect_state("R8 partial cmd dropped");

        // R9 STOP inside an output byte
        start_cond();
        send_byte(ADDR_OK, 1'b1, "R3 addr");
        send_byte(8'h05, 1'b1, "R9 cmd ch5");
        send_byte(8'h42, 1'b1, "R9 data");
        send_byte(8'h0E, 1'b1, "R9 cmd pd ch6");
        send_bits(8'hF0, 4, -1);
        stop_cond();
        exp_w[5] = 8'h42; exp_pd = 1'b1;
        expect_state("R9 flags kept data dropped");
        start_cond();
        send_byte(ADDR_OK, 1'b1, "R3 addr");
        send_byte(8'h10, 1'b1, "R9 cmd rst");
        send_bits(8'hFF, 3, -1);
        stop_cond();
        for (int i = 0; i < 8; i++) exp_w[i] = 8'h00;
        exp_pd = 1'b0;
        expect_state("R9 rst applied early stop");

        // R10 repeated START to another device
        start_cond();
        send_byte(ADDR_OK, 1'b1, "R3 addr");
        send_byte(8'h01, 1'b1, "R10 cmd ch1");
        send_byte(8'hA5, 1'b1, "R10 data");
        start_cond();
        send_byte(8'h5E, 1'b0, "R10 other addr");
        send_byte(8'h02, 1'b0, "R10 other cmd");
        send_byte(8'h33, 1'b0, "R10 other data");
        stop_cond();
        expect_state("R10 no commit");
        start_cond();
        send_byte(ADDR_OK, 1'b1, "R3 addr");
        send_byte(8'h00, 1'b1, "R10 lone cmd");
        stop_cond();
        exp_w[1] = 8'hA5;
        expect_state("R10 later commit");

        // R11 short clock glitch inside a byte
        start_cond();
        send_byte(ADDR_OK, 1'b1, "R3 addr");
        send_byte(8'h07, 1'b1, "R11 cmd ch7");
        send_byte(8'hC3, 1'b1, "R11 data glitch", 3);
        stop_cond();
        exp_w[7] = 8'hC3;
        expect_state("R11 glitch filtered");

        wq(4);
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule